// File: doc/BRIEF.md
# NMI Context Save and Restore Registers

This unit sits next to a 32-bit CPU core and keeps the state needed to return from a non-maskable interrupt. When the core accepts an NMI, it pulses a strobe together with the return address, the current processor status word and a 16-bit event code. In that cycle the unit stores the return address and the status word. It also places the event code in the upper half of a combined cause register. Maskable exceptions and interrupts report their own 16-bit code into the lower half of the same cause register.

On a return-from-interrupt pulse, the unit presents the saved address and status word on registered restore outputs for one cycle, flagged by a valid bit. Software reaches the saved address and saved status word through a small system-register port and may change them there. The cause register can only be read. Only one save set exists. The saved address keeps 26 bits, the saved status word keeps 8 bits, and every bit above those reads as zero.

Top module: `nmi_ctx_regs`

## Requirements
- R1: When `nmi_take` is high at a clock edge, the saved address takes `nmi_ret_pc[25:0]` and the saved status takes `nmi_psw[7:0]` at that same edge.
- R2: Bits 31..26 of the saved address always read as zero, whether the value came from an NMI capture or from a software write.
- R3: Bits 31..8 of the saved status always read as zero, whether the value came from an NMI capture or from a software write.
- R4: When `nmi_take` is high at an edge, cause bits 31..16 take `nmi_code`.
- R5: When `exc_take` is high at an edge, cause bits 15..0 take `exc_code` and cause bits 31..16 keep their value. If both strobes are high together, both halves update.
- R6: A software write with `sr_sel`=2 (cause) has no effect on the cause register.
- R7: While `rst` is high at an edge, the cause register clears to 0x00000000, `sr_rdata` clears to 0 and `rst_valid` clears to 0.
- R8: When `reti` is high at an edge, then after that edge `rst_pc` and `rst_psw` hold the saved values as they stood before the edge, zero-extended, and `rst_valid` is 1. `rst_valid` returns to 0 after the first edge at which `reti` is low.
- R9: A second NMI overwrites the saved address, the saved status and the upper cause field. The lower cause field is left alone.
- R10: The select codes are: `sr_sel` 0 = saved address, 1 = saved status, 2 = cause, 3 = unused (reads zero, writes ignored). When `sr_we` is high at an edge, the selected writable register takes `sr_wdata`. `sr_rdata` is registered: after each edge it shows the register chosen by `sr_sel` as it stood before that edge.
- R11: If `nmi_take` and a software write to the saved address or saved status occur in the same cycle, the NMI capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_take | input | 1 | NMI accepted this cycle |
| nmi_ret_pc | input | 32 | Return address supplied by the core |
| nmi_psw | input | 32 | Current status word |
| nmi_code | input | 16 | NMI event code |
| exc_take | input | 1 | Maskable exception accepted this cycle |
| exc_code | input | 16 | Maskable event code |
| reti | input | 1 | Return-from-interrupt pulse |
| sr_sel | input | 2 | System-register select |
| sr_we | input | 1 | System-register write enable |
| sr_wdata | input | 32 | System-register write data |
| sr_rdata | output | 32 | Registered read data |
| rst_pc | output | 32 | Restored address |
| rst_psw | output | 32 | Restored status word |
| rst_valid | output | 1 | Restore outputs valid this cycle |

## Verification
The bench fills the saved address and status with all-ones input patterns to catch a design that stores or leaks reserved bits. It writes a distinctive word to the cause select, which a design that failed to block software writes would expose. A maskable event that follows an NMI, and a second NMI after that, catch a cause register that clears the wrong half or a save set that refuses to overwrite. A same-cycle NMI and software write catch inverted priority. The return pulse is checked for one-cycle validity, which a design with an extra or missing register stage would miss.

// File: rtl/nmi_ctx_pkg.sv
package nmi_ctx_pkg;
  typedef enum logic [1:0] {
    SEL_SPC   = 2'd0,
    SEL_SPSW  = 2'd1,
    SEL_CAUSE = 2'd2,
    SEL_NONE  = 2'd3
  } sr_sel_e;
endpackage

// File: rtl/ctx_hold_reg.sv
// Saved-state register: hardware capture has priority over a software write.
// Only KEEP_W bits are stored; the rest of the word is constant zero.
module ctx_hold_reg #(
  parameter int KEEP_W = 26
) (
  input  logic              clk,
  input  logic              cap_en,
  input  logic [KEEP_W-1:0] cap_d,
  input  logic              wr_en,
  input  logic [KEEP_W-1:0] wr_d,
  output logic [KEEP_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (cap_en)     q <= cap_d;
    else if (wr_en) q <= wr_d;
  end
endmodule

// File: rtl/cause_reg.sv
// Combined cause register: upper half from NMI, lower half from maskable events.
module cause_reg #(
  parameter int CODE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                nmi_en,
  input  logic [CODE_W-1:0]   nmi_code,
  input  logic                exc_en,
  input  logic [CODE_W-1:0]   exc_code,
  output logic [2*CODE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (nmi_en) q[2*CODE_W-1:CODE_W] <= nmi_code;
      if (exc_en) q[CODE_W-1:0]        <= exc_code;
    end
  end
endmodule

// File: rtl/sr_read_mux.sv
// Registered read path of the system-register port.
module sr_read_mux
  import nmi_ctx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      sel,
  input  logic [XLEN-1:0] spc,
  input  logic [XLEN-1:0] spsw,
  input  logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] mux_d;

  always_comb begin
    unique case (sr_sel_e'(sel))
      SEL_SPC:   mux_d = spc;
      SEL_SPSW:  mux_d = spsw;
      SEL_CAUSE: mux_d = cause;
      default:   mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mux_d;
  end
endmodule

// File: rtl/nmi_ctx_regs.sv
module nmi_ctx_regs
  import nmi_ctx_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int PC_KEEP  = 26,
  parameter int PSW_KEEP = 8,
  parameter int CODE_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_take,
  input  logic [XLEN-1:0]   nmi_ret_pc,
  input  logic [XLEN-1:0]   nmi_psw,
  input  logic [CODE_W-1:0] nmi_code,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              reti,
  input  logic [1:0]        sr_sel,
  input  logic              sr_we,
  input  logic [XLEN-1:0]   sr_wdata,
  output logic [XLEN-1:0]   sr_rdata,
  output logic [XLEN-1:0]   rst_pc,
  output logic [XLEN-1:0]   rst_psw,
  output logic              rst_valid
);
  localparam int PC_PAD  = XLEN - PC_KEEP;
  localparam int PSW_PAD = XLEN - PSW_KEEP;

  logic [PC_KEEP-1:0]  spc_q;
  logic [PSW_KEEP-1:0] spsw_q;
  logic [XLEN-1:0]     cause_q;
  logic [XLEN-1:0]     spc_word, spsw_word;
  logic                wr_spc, wr_spsw;

  // Writes to the cause select and the unused select decode to nothing (R6).
  assign wr_spc  = sr_we && (sr_sel_e'(sr_sel) == SEL_SPC);
  assign wr_spsw = sr_we && (sr_sel_e'(sr_sel) == SEL_SPSW);

  // Reserved bits are zero-filled here for every consumer (R2, R3).
  assign spc_word  = {{PC_PAD{1'b0}},  spc_q};
  assign spsw_word = {{PSW_PAD{1'b0}}, spsw_q};

  ctx_hold_reg #(.KEEP_W(PC_KEEP)) u_spc (
    .clk    (clk),
    .cap_en (nmi_take),
    .cap_d  (nmi_ret_pc[PC_KEEP-1:0]),
    .wr_en  (wr_spc),
    .wr_d   (sr_wdata[PC_KEEP-1:0]),
    .q      (spc_q)
  );

  ctx_hold_reg #(.KEEP_W(PSW_KEEP)) u_spsw (
    .clk    (clk),
    .cap_en (nmi_take),
    .cap_d  (nmi_psw[PSW_KEEP-1:0]),
    .wr_en  (wr_spsw),
    .wr_d   (sr_wdata[PSW_KEEP-1:0]),
    .q      (spsw_q)
  );

  cause_reg #(.CODE_W(CODE_W)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .nmi_en   (nmi_take),
    .nmi_code (nmi_code),
    .exc_en   (exc_take),
    .exc_code (exc_code),
    .q        (cause_q)
  );

  sr_read_mux #(.XLEN(XLEN)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .sel   (sr_sel),
    .spc   (spc_word),
    .spsw  (spsw_word),
    .cause (cause_q),
    .rdata (sr_rdata)
  );

  // Restore outputs, registered (R8).
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_valid <= 1'b0;
      rst_pc    <= '0;
      rst_psw   <= '0;
    end else begin
      rst_valid <= reti;
      if (reti) begin
        rst_pc  <= spc_word;
        rst_psw <= spsw_word;
      end
    end
  end
endmodule

// File: rtl/nmi_ctx_chk.sv
module nmi_ctx_chk #(
  parameter int XLEN     = 32,
  parameter int PC_KEEP  = 26,
  parameter int PSW_KEEP = 8,
  parameter int CODE_W   = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                nmi_take,
  input logic [XLEN-1:0]     nmi_ret_pc,
  input logic [XLEN-1:0]     nmi_psw,
  input logic [CODE_W-1:0]   nmi_code,
  input logic                exc_take,
  input logic                reti,
  input logic [1:0]          sr_sel,
  input logic                sr_we,
  input logic [XLEN-1:0]     sr_rdata,
  input logic [XLEN-1:0]     rst_pc,
  input logic                rst_valid,
  input logic [PC_KEEP-1:0]  spc_q,
  input logic [PSW_KEEP-1:0] spsw_q,
  input logic [XLEN-1:0]     cause_q
);
  p_nmi_pc_r1: assert property (@(posedge clk) disable iff (rst)
    nmi_take |=> spc_q == $past(nmi_ret_pc[PC_KEEP-1:0]));

  p_nmi_psw_r1: assert property (@(posedge clk) disable iff (rst)
    nmi_take |=> spsw_q == $past(nmi_psw[PSW_KEEP-1:0]));

  p_pc_resv_read_r2: assert property (@(posedge clk) disable iff (rst)
    (sr_sel == 2'd0) |=> sr_rdata[XLEN-1:PC_KEEP] == '0);

  p_psw_resv_read_r3: assert property (@(posedge clk) disable iff (rst)
    (sr_sel == 2'd1) |=> sr_rdata[XLEN-1:PSW_KEEP] == '0);

  p_nmi_code_r4: assert property (@(posedge clk) disable iff (rst)
    nmi_take |=> cause_q[XLEN-1:CODE_W] == $past(nmi_code));

  p_exc_keeps_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (exc_take && !nmi_take) |=> $stable(cause_q[XLEN-1:CODE_W]));

  p_cause_ro_r6: assert property (@(posedge clk) disable iff (rst)
    (sr_we && !nmi_take && !exc_take) |=> $stable(cause_q));

  p_cause_reset_r7: assert property (@(posedge clk)
    rst |=> (cause_q == '0 && !rst_valid && sr_rdata == '0));

  p_restore_r8: assert property (@(posedge clk) disable iff (rst)
    reti |=> (rst_valid && rst_pc == {{(XLEN-PC_KEEP){1'b0}}, $past(spc_q)}));

  p_restore_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !reti |=> !rst_valid);

  p_nmi_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (nmi_take && sr_we && sr_sel == 2'd0) |=> spc_q == $past(nmi_ret_pc[PC_KEEP-1:0]));
endmodule

bind nmi_ctx_regs nmi_ctx_chk #(
  .XLEN(XLEN), .PC_KEEP(PC_KEEP), .PSW_KEEP(PSW_KEEP), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .nmi_take(nmi_take), .nmi_ret_pc(nmi_ret_pc),
  .nmi_psw(nmi_psw), .nmi_code(nmi_code), .exc_take(exc_take), .reti(reti),
  .sr_sel(sr_sel), .sr_we(sr_we), .sr_rdata(sr_rdata), .rst_pc(rst_pc),
  .rst_valid(rst_valid), .spc_q(spc_q), .spsw_q(spsw_q), .cause_q(cause_q)
);

// File: tb/sim_nmi_ctx_regs.sv
`timescale 1ns/1ps
module sim_nmi_ctx_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_take = 1'b0, exc_take = 1'b0, reti = 1'b0, sr_we = 1'b0;
  logic [31:0] nmi_ret_pc = '0, nmi_psw = '0, sr_wdata = '0;
  logic [15:0] nmi_code = '0, exc_code = '0;
  logic [1:0]  sr_sel = '0;
  logic [31:0] sr_rdata, rst_pc, rst_psw;
  logic        rst_valid;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nmi_ctx_regs u0 (
    .clk(clk), .rst(rst), .nmi_take(nmi_take), .nmi_ret_pc(nmi_ret_pc),
    .nmi_psw(nmi_psw), .nmi_code(nmi_code), .exc_take(exc_take),
    .exc_code(exc_code), .reti(reti), .sr_sel(sr_sel), .sr_we(sr_we),
    .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .rst_pc(rst_pc),
    .rst_psw(rst_psw), .rst_valid(rst_valid)
  );

  // op: 0 idle, 1 NMI, 2 maskable event, 3 software write
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sel;
    logic [31:0] d0;
    logic [31:0] d1;
    logic [15:0] code;
    logic [1:0]  rsel;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 2'd0, 32'hFFFF_FFF4, 32'hFFFF_FFA5, 16'h0010, 2'd0, 32'h03FF_FFF4, 8'd1},  // R1 R2
    '{2'd0, 2'd0, 32'h0,         32'h0,         16'h0,    2'd1, 32'h0000_00A5, 8'd3},  // R3
    '{2'd0, 2'd0, 32'h0,         32'h0,         16'h0,    2'd2, 32'h0010_0000, 8'd4},  // R4
    '{2'd2, 2'd0, 32'h0,         32'h0,         16'h0041, 2'd2, 32'h0010_0041, 8'd5},  // R5
    '{2'd3, 2'd2, 32'hDEAD_BEEF, 32'h0,         16'h0,    2'd2, 32'h0010_0041, 8'd6},  // R6
    '{2'd3, 2'd0, 32'hABCD_1234, 32'h0,         16'h0,    2'd0, 32'h03CD_1234, 8'd10}, // R10 R2
    '{2'd3, 2'd1, 32'h1234_5678, 32'h0,         16'h0,    2'd1, 32'h0000_0078, 8'd3},  // R3 R10
    '{2'd1, 2'd0, 32'h0000_2000, 32'h0000_0011, 16'h0020, 2'd0, 32'h0000_2000, 8'd9},  // R9
    '{2'd0, 2'd0, 32'h0,         32'h0,         16'h0,    2'd2, 32'h0020_0041, 8'd9},  // R9
    '{2'd3, 2'd3, 32'hFFFF_FFFF, 32'h0,         16'h0,    2'd3, 32'h0000_0000, 8'd10}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    nmi_take   = (v.op == 2'd1);
    exc_take   = (v.op == 2'd2);
    sr_we      = (v.op == 2'd3);
    sr_sel     = v.sel;
    nmi_ret_pc = v.d0;
    sr_wdata   = v.d0;
    nmi_psw    = v.d1;
    nmi_code   = v.code;
    exc_code   = v.code;
    @(negedge clk);
    nmi_take = 0; exc_take = 0; sr_we = 0;
  endtask

  task automatic read_reg(input logic [1:0] s, output logic [31:0] val);
    sr_sel = s;
    @(negedge clk);
    val = sr_rdata;
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 rdata", sr_rdata, 32'h0);
    check("R7 valid", {31'b0, rst_valid}, 32'h0);
    rst = 0;
    read_reg(2'd2, rv);
    check("R7 cause", rv, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      read_reg(VEC[i].rsel, rv);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].expv);
    end

    // R8: return pulse presents saved values, valid for one cycle
    @(negedge clk);
    reti = 1;
    @(negedge clk);
    reti = 0;
    check("R8 pc",    rst_pc,  32'h0000_2000);
    check("R8 psw",   rst_psw, 32'h0000_0011);
    check("R8 valid", {31'b0, rst_valid}, 32'h1);
    @(negedge clk);
    check("R8 drop",  {31'b0, rst_valid}, 32'h0);

    // R11: NMI and write to saved address in the same cycle
    @(negedge clk);
    nmi_take = 1; nmi_ret_pc = 32'h0155_5554; nmi_psw = 32'h0; nmi_code = 16'h0033;
    sr_we = 1; sr_sel = 2'd0; sr_wdata = 32'h0000_0BAD;
    @(negedge clk);
    nmi_take = 0; sr_we = 0;
    read_reg(2'd0, rv);
    check("R11 pc", rv, 32'h0155_5554);

    // R5: NMI and maskable event together update both halves
    @(negedge clk);
    nmi_take = 1; nmi_code = 16'hA0A0; exc_take = 1; exc_code = 16'h0B0B;
    @(negedge clk);
    nmi_take = 0; exc_take = 0;
    read_reg(2'd2, rv);
    check("R5 both", rv, 32'hA0A0_0B0B);

    // R7: reset mid-run clears cause
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    read_reg(2'd2, rv);
    check("R7 cause after reset", rv, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule